// File: doc/BRIEF.md
# Software and Watchdog Reset Sequencer

This block drives three active-low reset outputs for a chip: one for the processor, one for the peripherals and one for an external reset pin. Software starts a reset by writing a keyed command on the fast master clock. The command picks any mix of the three outputs. A watchdog fault on the slow clock starts a watchdog reset. The internal resets assert on the master-clock edge that accepts the command. The length of each reset state is counted on the slow clock, so the request crosses to the slow domain and the completion crosses back.

A busy flag covers the whole software reset. While it is high, further commands are refused. A two-bit type field records the kind of the last reset that touched the processor: 3 for a software reset that selected the processor, 2 for a watchdog reset, and 0 after power-up. The external pin pulse lasts 2^(len+1) slow cycles, where len is a programmable length field. The block reads the pin back. A falling edge that the block caused itself must not be reported as a user reset, while a genuine external pull-down raises a one-cycle event.

Top module: `swrst_ctrl`

## Requirements
- R1: A write whose bits [31:24] equal 0xA5, with at least one of bit 0 (processor), bit 1 (peripheral) or bit 2 (external) set, is accepted while busy is low. On the accepting master-clock edge, busy goes high and each selected internal reset goes low. The selected resets stay low until busy falls.
- R2: A write with any other key, or with the key and none of the three bits set, is ignored. Busy stays low, no reset output moves, and the type field keeps its value.
- R3: While busy is high, every control write is ignored, including one that carries the key. The reset outputs and the type field stay as the accepted command left them.
- R4: The software reset state lasts 3 slow cycles. If the external bit is selected and 2^(len+1) is larger than 3, it lasts 2^(len+1) slow cycles instead. Busy and the internal resets are released only after this state ends, within the two synchroniser delays. A reset write holds the block in the first (asserted) state.
- R5: With the external bit selected, ext_rst_n is low for exactly 2^(len+1) consecutive slow cycles in a single pulse. Without the external bit it stays high.
- R6: The type field is 0 after reset. It becomes 3 only after a software reset that selected the processor bit, and software resets without that bit leave it unchanged.
- R7: A watchdog fault with wdt_proc_only low asserts both the processor and peripheral resets for max(3, 2^(len+1)) slow cycles, drives ext_rst_n low for 2^(len+1) slow cycles, and sets the type field to 2.
- R8: A watchdog fault with wdt_proc_only high asserts only the processor reset, for 3 slow cycles. It leaves ext_rst_n high and sets the type field to 2.
- R9: A falling edge on pin_sense raises user_evt for one slow cycle. The exception is an edge that occurs while the block drives ext_rst_n or within 4 slow cycles after it stops, which raises no event.
- R10: A watchdog fault and a software request that are waiting in the same slow cycle are served watchdog first, then software. A fault or request that arrives during an active reset state waits for that state to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Fast master clock for the control write and status |
| sclk | input | 1 | Slow clock that times the reset states |
| rst_n | input | 1 | Active-low reset, synchronous in both clock domains |
| ctl_wr | input | 1 | Control write strobe (master clock) |
| ctl_wdata | input | 32 | Control word: key in [31:24], processor bit 0, peripheral bit 1, external bit 2 |
| ext_len | input | 2 | External pulse length field; pulse is 2^(ext_len+1) slow cycles |
| wdt_fault | input | 1 | Watchdog fault, one slow-clock cycle wide |
| wdt_proc_only | input | 1 | Watchdog option: 1 resets the processor alone |
| pin_sense | input | 1 | Level sensed on the external reset pin |
| proc_rst_n | output | 1 | Processor reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| ext_rst_n | output | 1 | External pin drive, active low |
| busy | output | 1 | Software reset in progress (master clock) |
| rst_type | output | 2 | Last reset type: 0 power-up, 2 watchdog, 3 software |
| user_evt | output | 1 | One-cycle event for an external pull-down of the pin (slow clock) |

## Verification
The slow-clock sequencer can find a watchdog fault and a synchronised software request pending in the same idle cycle. The bench sets this up deliberately: it starts a processor-only watchdog reset, writes a software command during it, and raises a second fault that does not select processor-only during the same state. When the first state ends, both requests are waiting. The outcome is judged from the ports: the second watchdog's external pin pulse must appear before the type field turns to 3, the pulse must have the watchdog's length, and busy must cover both states.

// File: rtl/swrst_pkg.sv
// Package swrst_pkg
// Shared encodings for the reset sequencer: command bit positions,
// the reset-type codes and the selection record passed between domains.
package swrst_pkg;

    // Position of the selection bits inside the control word
    localparam int SEL_PROC_BIT   = 0;
    localparam int SEL_PERIPH_BIT = 1;
    localparam int SEL_EXT_BIT    = 2;

    // Reset-type codes reported in the status field
    typedef enum logic [1:0] {
        RK_POWERUP = 2'd0,
        RK_WDT     = 2'd2,
        RK_SOFT    = 2'd3
    } rst_kind_e;

    // Which outputs an accepted software command selects
    typedef struct packed {
        logic ext;
        logic periph;
        logic proc;
    } rst_sel_t;

endpackage

// File: rtl/swrst_tsync.sv
// Module swrst_tsync
// Carries a toggle across into the clk domain through STAGES flops and
// turns each change into a one-cycle pulse.
// Assumes: the source toggles at most once every few destination cycles
// and holds any data that goes with it stable until after the pulse.
module swrst_tsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse_out
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the toggle through the synchroniser and keep the previous level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q[0] <= tgl_in;
            for (int i = 1; i < STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            last_q <= sync_q[STAGES-1];
        end
    end

    assign pulse_out = sync_q[STAGES-1] ^ last_q;

    // R4: a crossing event is a single pulse, never a held level
    assert_pulse_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |=> !pulse_out);

endmodule

// File: rtl/swrst_cmd.sv
// Module swrst_cmd
// Master-clock side: accepts keyed control writes, holds the busy flag and
// the selected outputs, and keeps the reset-type status.
// Assumes: done_p and ent_p arrive already synchronised to mclk, and
// ent_code is stable while ent_p is high.
module swrst_cmd
    import swrst_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter logic [7:0]  KEY    = 8'hA5
) (
    input  logic              mclk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              done_p,
    input  logic              ent_p,
    input  logic [1:0]        ent_code,
    output logic              busy,
    output rst_sel_t          sel,
    output logic              req_tgl,
    output logic [1:0]        rst_type
);

    logic     key_ok;
    rst_sel_t wr_sel;
    logic     accept;

    // Decode the key and the selection bits of the incoming write
    always_comb begin
        key_ok        = (ctl_wdata[DATA_W-1 -: 8] == KEY);
        wr_sel.proc   = ctl_wdata[SEL_PROC_BIT];
        wr_sel.periph = ctl_wdata[SEL_PERIPH_BIT];
        wr_sel.ext    = ctl_wdata[SEL_EXT_BIT];
        accept        = ctl_wr && key_ok && !busy && (wr_sel != '0);
    end

    // Take a command, hold it while busy, drop it when the slow side is done
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            sel     <= '0;
            req_tgl <= 1'b0;
        end else if (accept) begin
            busy    <= 1'b1;
            sel     <= wr_sel;
            req_tgl <= ~req_tgl;
        end else if (done_p) begin
            busy    <= 1'b0;
            sel     <= '0;
        end
    end

    // Record the type of each reset state the slow side enters
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            rst_type <= RK_POWERUP;
        end else if (ent_p) begin
            rst_type <= ent_code;
        end
    end

    // R1: a keyed write with a selection while idle raises busy
    assert_accept_busy_R1: assert property (@(posedge mclk) disable iff (!rst_n)
        (ctl_wr && !busy && key_ok && (wr_sel != '0)) |=> busy);

    // R2: a write with the wrong key leaves the idle block idle
    assert_bad_key_idle_R2: assert property (@(posedge mclk) disable iff (!rst_n)
        (ctl_wr && !busy && !key_ok && !done_p) |=> !busy);

    // R3: while busy, writes cannot change the held selection
    assert_lockout_R3: assert property (@(posedge mclk) disable iff (!rst_n)
        (busy && !done_p) |=> (busy && $stable(sel)));

    // R6: only the three defined type codes ever appear
    assert_type_legal_R6: assert property (@(posedge mclk) disable iff (!rst_n)
        rst_type != 2'd1);

endmodule

// File: rtl/swrst_seq.sv
// Module swrst_seq
// Slow-clock sequencer: runs one reset state at a time, watchdog before
// software, counts its length and the external pulse, and toggles flags
// for state entry and for the end of a software state.
// Assumes: sel is quasi-static while a software request is pending, and
// wdt_fault is one sclk cycle wide.
module swrst_seq
    import swrst_pkg::*;
#(
    parameter int LEN_W      = 2,
    parameter int BASE_CYC   = 3
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             sw_req,
    input  rst_sel_t         sel,
    input  logic [LEN_W-1:0] ext_len,
    input  logic             wdt_fault,
    input  logic             wdt_proc_only,
    output logic             ext_drive,
    output logic             wdt_proc_hold,
    output logic             wdt_periph_hold,
    output logic             done_tgl,
    output logic             ent_tgl,
    output logic [1:0]       ent_code
);

    localparam int CNT_W = (1 << LEN_W) + 1;
    localparam logic [CNT_W-1:0] BASE = CNT_W'(BASE_CYC);

    logic             act;
    logic             is_wdt;
    logic             po_q;
    logic             ext_en;
    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] span;
    logic [CNT_W-1:0] pulse;
    logic             sw_pend;
    logic             wdt_pend;

    logic [CNT_W-1:0] plen;
    logic [CNT_W-1:0] long_span;
    logic             start_wdt;
    logic             start_sw;
    logic             last_cyc;

    // Pulse length from the field and the arbitration between requests
    always_comb begin
        plen      = CNT_W'(1) << ({1'b0, ext_len} + 1'b1);
        long_span = (plen > BASE) ? plen : BASE;
        start_wdt = !act && (wdt_fault || wdt_pend);
        start_sw  = !act && !start_wdt && (sw_req || sw_pend);
        last_cyc  = act && (elapsed == span - 1'b1);
    end

    // Enter, count and leave reset states
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            act      <= 1'b0;
            is_wdt   <= 1'b0;
            po_q     <= 1'b0;
            ext_en   <= 1'b0;
            elapsed  <= '0;
            span     <= BASE;
            pulse    <= '0;
            done_tgl <= 1'b0;
            ent_tgl  <= 1'b0;
            ent_code <= RK_POWERUP;
        end else if (start_wdt) begin
            act      <= 1'b1;
            is_wdt   <= 1'b1;
            po_q     <= wdt_proc_only;
            ext_en   <= !wdt_proc_only;
            elapsed  <= '0;
            span     <= wdt_proc_only ? BASE : long_span;
            pulse    <= plen;
            ent_tgl  <= ~ent_tgl;
            ent_code <= RK_WDT;
        end else if (start_sw) begin
            act      <= 1'b1;
            is_wdt   <= 1'b0;
            po_q     <= 1'b0;
            ext_en   <= sel.ext;
            elapsed  <= '0;
            span     <= sel.ext ? long_span : BASE;
            pulse    <= plen;
            if (sel.proc) begin
                ent_tgl  <= ~ent_tgl;
                ent_code <= RK_SOFT;
            end
        end else if (last_cyc) begin
            act <= 1'b0;
            if (!is_wdt) begin
                done_tgl <= ~done_tgl;
            end
        end else if (act) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // Hold requests that arrive while a state is running
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            sw_pend  <= 1'b0;
            wdt_pend <= 1'b0;
        end else begin
            sw_pend  <= start_sw  ? 1'b0 : (sw_pend  || sw_req);
            wdt_pend <= start_wdt ? 1'b0 : (wdt_pend || wdt_fault);
        end
    end

    assign ext_drive       = act && ext_en && (elapsed < pulse);
    assign wdt_proc_hold   = act && is_wdt;
    assign wdt_periph_hold = act && is_wdt && !po_q;

    // R4: a running state is never cut short before its last cycle
    assert_state_runs_full_R4: assert property (@(posedge sclk) disable iff (!rst_n)
        (act && (elapsed != span - 1'b1)) |=> (act && elapsed == $past(elapsed) + 1'b1));

    // R5: the pin drive stays inside the state that owns it
    assert_pulse_in_state_R5: assert property (@(posedge sclk) disable iff (!rst_n)
        ext_drive |-> (elapsed < span));

    // R8: a processor-only watchdog state never drives the pin
    assert_proc_only_quiet_R8: assert property (@(posedge sclk) disable iff (!rst_n)
        (wdt_proc_hold && !wdt_periph_hold) |-> !ext_drive);

    // R10: an idle sequencer with a waiting fault serves the watchdog first
    assert_wdt_first_R10: assert property (@(posedge sclk) disable iff (!rst_n)
        (!act && (wdt_fault || wdt_pend)) |=> (act && is_wdt));

endmodule

// File: rtl/swrst_pinwatch.sv
// Module swrst_pinwatch
// Watches the sensed pin level on the slow clock and reports external
// pull-downs, masking edges while the block drives the pin and for a
// guard window afterwards.
// Assumes: the pin follows the drive within the synchroniser delay.
module swrst_pinwatch #(
    parameter int GUARD = 4
) (
    input  logic sclk,
    input  logic rst_n,
    input  logic pin_sense,
    input  logic self_drive,
    output logic user_evt
);

    localparam int GW = $clog2(GUARD + 1);

    logic [1:0]    pin_sync;
    logic          pin_prev;
    logic [GW-1:0] guard_cnt;
    logic          fall;

    // Bring the pin into the slow domain and remember the last level
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            pin_sync <= 2'b11;
            pin_prev <= 1'b1;
        end else begin
            pin_sync <= {pin_sync[0], pin_sense};
            pin_prev <= pin_sync[1];
        end
    end

    assign fall = pin_prev && !pin_sync[1];

    // Reload the guard window while driving, then count it down
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            guard_cnt <= '0;
        end else if (self_drive) begin
            guard_cnt <= GW'(GUARD);
        end else if (guard_cnt != '0) begin
            guard_cnt <= guard_cnt - 1'b1;
        end
    end

    // Flag a falling edge only when no mask is in force
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            user_evt <= 1'b0;
        end else begin
            user_evt <= fall && !self_drive && (guard_cnt == '0);
        end
    end

    // R9: no event follows a cycle in which the block drove the pin
    assert_no_self_event_R9: assert property (@(posedge sclk) disable iff (!rst_n)
        user_evt |-> (!$past(self_drive) && !$past(self_drive, 2)));

endmodule

// File: rtl/swrst_ctrl.sv
// Module swrst_ctrl
// Top of the reset sequencer: joins the master-clock command side, the
// slow-clock sequencer, the pin watcher and the three crossings, and
// merges software and watchdog holds into the active-low outputs.
// Assumes: rst_n is held low for at least STAGES+1 slow cycles.
module swrst_ctrl
    import swrst_pkg::*;
#(
    parameter int         DATA_W   = 32,
    parameter logic [7:0] KEY      = 8'hA5,
    parameter int         LEN_W    = 2,
    parameter int         BASE_CYC = 3,
    parameter int         STAGES   = 2,
    parameter int         GUARD    = 4
) (
    input  logic              mclk,
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic [LEN_W-1:0]  ext_len,
    input  logic              wdt_fault,
    input  logic              wdt_proc_only,
    input  logic              pin_sense,
    output logic              proc_rst_n,
    output logic              periph_rst_n,
    output logic              ext_rst_n,
    output logic              busy,
    output logic [1:0]        rst_type,
    output logic              user_evt
);

    rst_sel_t   sel;
    logic       req_tgl;
    logic       req_p;
    logic       done_tgl;
    logic       done_p;
    logic       ent_tgl;
    logic       ent_p;
    logic [1:0] ent_code;
    logic       ext_drive;
    logic       wdt_proc_hold;
    logic       wdt_periph_hold;

    swrst_cmd #(
        .DATA_W (DATA_W),
        .KEY    (KEY)
    ) u_cmd (
        .mclk      (mclk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .done_p    (done_p),
        .ent_p     (ent_p),
        .ent_code  (ent_code),
        .busy      (busy),
        .sel       (sel),
        .req_tgl   (req_tgl),
        .rst_type  (rst_type)
    );

    swrst_tsync #(.STAGES(STAGES)) u_req_sync (
        .clk       (sclk),
        .rst_n     (rst_n),
        .tgl_in    (req_tgl),
        .pulse_out (req_p)
    );

    swrst_seq #(
        .LEN_W    (LEN_W),
        .BASE_CYC (BASE_CYC)
    ) u_seq (
        .sclk            (sclk),
        .rst_n           (rst_n),
        .sw_req          (req_p),
        .sel             (sel),
        .ext_len         (ext_len),
        .wdt_fault       (wdt_fault),
        .wdt_proc_only   (wdt_proc_only),
        .ext_drive       (ext_drive),
        .wdt_proc_hold   (wdt_proc_hold),
        .wdt_periph_hold (wdt_periph_hold),
        .done_tgl        (done_tgl),
        .ent_tgl         (ent_tgl),
        .ent_code        (ent_code)
    );

    swrst_tsync #(.STAGES(STAGES)) u_done_sync (
        .clk       (mclk),
        .rst_n     (rst_n),
        .tgl_in    (done_tgl),
        .pulse_out (done_p)
    );

    swrst_tsync #(.STAGES(STAGES)) u_ent_sync (
        .clk       (mclk),
        .rst_n     (rst_n),
        .tgl_in    (ent_tgl),
        .pulse_out (ent_p)
    );

    swrst_pinwatch #(.GUARD(GUARD)) u_pin (
        .sclk       (sclk),
        .rst_n      (rst_n),
        .pin_sense  (pin_sense),
        .self_drive (ext_drive),
        .user_evt   (user_evt)
    );

    assign proc_rst_n   = !((busy && sel.proc)   || wdt_proc_hold);
    assign periph_rst_n = !((busy && sel.periph) || wdt_periph_hold);
    assign ext_rst_n    = !ext_drive;

    // R1: a selected processor hold persists until busy drops
    assert_proc_held_R1: assert property (@(posedge mclk) disable iff (!rst_n)
        (busy && sel.proc && !done_p) |=> !proc_rst_n);

endmodule

// File: tb/swrst_ctrl_bench.sv
module swrst_ctrl_bench;

    logic        mclk = 1'b0;
    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [1:0]  ext_len = '0;
    logic        wdt_fault = 1'b0;
    logic        wdt_proc_only = 1'b0;
    logic        force_low = 1'b0;
    logic        pin_sense;
    logic        proc_rst_n, periph_rst_n, ext_rst_n, busy, user_evt;
    logic [1:0]  rst_type;

    int checks = 0;
    int errors = 0;
    int evt_cnt = 0;
    int exp_type = 0;
    bit finished = 0;

    assign pin_sense = ext_rst_n && !force_low;

    swrst_ctrl u_swrst_ctrl (
        .mclk          (mclk),
        .sclk          (sclk),
        .rst_n         (rst_n),
        .ctl_wr        (ctl_wr),
        .ctl_wdata     (ctl_wdata),
        .ext_len       (ext_len),
        .wdt_fault     (wdt_fault),
        .wdt_proc_only (wdt_proc_only),
        .pin_sense     (pin_sense),
        .proc_rst_n    (proc_rst_n),
        .periph_rst_n  (periph_rst_n),
        .ext_rst_n     (ext_rst_n),
        .busy          (busy),
        .rst_type      (rst_type),
        .user_evt      (user_evt)
    );

    // 50 MHz master clock; slow clock at 1/10 rate with an offset phase
    always #10 mclk = ~mclk;
    initial begin
        #53;
        forever #100 sclk = ~sclk;
    end

    always @(negedge sclk) if (user_evt) evt_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pulse_of(input int len);
        return 1 << (len + 1);
    endfunction

    function automatic int span_of(input bit ext, input int len);
        if (ext && pulse_of(len) > 3) return pulse_of(len);
        return 3;
    endfunction

    task automatic write_ctl(input logic [7:0] key, input logic [2:0] bits);
        @(negedge mclk);
        ctl_wr    = 1'b1;
        ctl_wdata = {key, 21'd0, bits};
        @(negedge mclk);
        ctl_wr    = 1'b0;
    endtask

    // One software command, measured from the ports until busy falls
    task automatic sw_run(input logic [7:0] key, input logic [2:0] bits, input int len,
                          input bit lock_probe);
        bit accept = (key == 8'hA5) && (bits != 3'b000);
        int busy_cyc = 0, ext_low = 0, runs = 0, hold_bad = 0, evt_base;
        bit prev = 1'b1;
        evt_base = evt_cnt;
        ext_len  = 2'(len);
        write_ctl(key, bits);
        chk(busy == accept, accept ? "R1 busy" : "R2 busy", busy, accept);
        chk(proc_rst_n == !(accept && bits[0]), accept ? "R1 proc" : "R2 proc",
            proc_rst_n, !(accept && bits[0]));
        chk(periph_rst_n == !(accept && bits[1]), accept ? "R1 periph" : "R2 periph",
            periph_rst_n, !(accept && bits[1]));
        if (!accept) begin
            for (int i = 0; i < 8; i++) begin
                @(negedge sclk);
                if (!ext_rst_n || busy || !proc_rst_n || !periph_rst_n) hold_bad++;
            end
            chk(hold_bad == 0, "R2 no activity", hold_bad, 0);
            chk(rst_type == 2'(exp_type), "R2 type kept", rst_type, exp_type);
            return;
        end
        if (lock_probe) begin
            write_ctl(8'hA5, 3'b111);
            chk(proc_rst_n == !bits[0], "R3 proc unchanged", proc_rst_n, !bits[0]);
            chk(busy == 1'b1, "R3 still busy", busy, 1);
        end
        do begin
            @(negedge sclk);
            if (busy) begin
                busy_cyc++;
                if (proc_rst_n != !bits[0] || periph_rst_n != !bits[1]) hold_bad++;
            end
            if (!ext_rst_n) begin
                ext_low++;
                if (prev) runs++;
            end
            prev = ext_rst_n;
        end while (busy && busy_cyc < 100);
        chk(ext_low == (bits[2] ? pulse_of(len) : 0), "R5 pulse length", ext_low,
            bits[2] ? pulse_of(len) : 0);
        chk(runs == (bits[2] ? 1 : 0), "R5 single pulse", runs, bits[2] ? 1 : 0);
        chk(busy_cyc >= span_of(bits[2], len) && busy_cyc <= span_of(bits[2], len) + 4,
            "R4 state length", busy_cyc, span_of(bits[2], len));
        chk(hold_bad == 0, "R1 held while busy", hold_bad, 0);
        @(negedge mclk);
        chk(proc_rst_n && periph_rst_n && ext_rst_n, "R4 released",
            {proc_rst_n, periph_rst_n, ext_rst_n}, 7);
        if (bits[0]) exp_type = 3;
        chk(rst_type == 2'(exp_type), "R6 type", rst_type, exp_type);
        chk(evt_cnt == evt_base, "R9 self edge masked", evt_cnt, evt_base);
    endtask

    // One watchdog fault, counted in slow cycles from the ports
    task automatic wdt_run(input bit po, input int len);
        int proc_cyc = 0, ext_low = 0, per_bad = 0, evt_base;
        evt_base = evt_cnt;
        ext_len  = 2'(len);
        @(negedge sclk);
        wdt_fault     = 1'b1;
        wdt_proc_only = po;
        @(negedge sclk);
        wdt_fault     = 1'b0;
        while (!proc_rst_n && proc_cyc < 100) begin
            proc_cyc++;
            if (!ext_rst_n) ext_low++;
            if (periph_rst_n != po) per_bad++;
            @(negedge sclk);
        end
        chk(proc_cyc == (po ? 3 : span_of(1'b1, len)), po ? "R8 proc length" : "R7 proc length",
            proc_cyc, po ? 3 : span_of(1'b1, len));
        chk(ext_low == (po ? 0 : pulse_of(len)), po ? "R8 pin quiet" : "R7 pin pulse",
            ext_low, po ? 0 : pulse_of(len));
        chk(per_bad == 0, po ? "R8 periph free" : "R7 periph held", per_bad, 0);
        repeat (4) @(negedge mclk);
        exp_type = 2;
        chk(rst_type == 2'd2, po ? "R8 type" : "R7 type", rst_type, 2);
        chk(evt_cnt == evt_base, "R9 watchdog edge masked", evt_cnt, evt_base);
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge sclk);
        @(negedge mclk);
        chk(proc_rst_n && periph_rst_n && ext_rst_n, "R4 reset holds outputs off",
            {proc_rst_n, periph_rst_n, ext_rst_n}, 7);
        rst_n = 1'b1;
        @(negedge mclk);
        chk(busy == 1'b0, "R1 reset busy", busy, 0);
        chk(rst_type == 2'd0, "R6 reset type", rst_type, 0);
        chk(user_evt == 1'b0, "R9 reset event", user_evt, 0);

        // R2: wrong keys and an empty selection
        sw_run(8'h00, 3'b111, 1, 1'b0);
        sw_run(8'hA4, 3'b111, 1, 1'b0);
        sw_run(8'h5A, 3'b011, 1, 1'b0);
        sw_run(8'hA5, 3'b000, 1, 1'b0);

        // R1, R4, R5, R6: every selection under every length
        for (int len = 0; len < 4; len++) begin
            for (int b = 1; b < 8; b++) begin
                sw_run(8'hA5, 3'(b), len, 1'b0);
            end
        end

        // R3: lockout probe under a long command that leaves the type alone
        wdt_run(1'b1, 0);
        sw_run(8'hA5, 3'b110, 3, 1'b1);

        // R7, R8: watchdog under both options and every length
        for (int len = 0; len < 4; len++) begin
            wdt_run(1'b0, len);
            wdt_run(1'b1, len);
        end

        // R9: a genuine external pull-down
        begin
            int base = evt_cnt;
            @(negedge sclk);
            force_low = 1'b1;
            repeat (4) @(negedge sclk);
            force_low = 1'b0;
            repeat (4) @(negedge sclk);
            chk(evt_cnt == base + 1, "R9 user edge", evt_cnt, base + 1);
        end

        // R10: watchdog and software request waiting in the same idle cycle
        begin
            int ext_idx = -1, t3_idx = -1, ext_low = 0, idx = 0;
            ext_len = 2'd2;
            @(negedge sclk);
            wdt_fault = 1'b1;
            wdt_proc_only = 1'b1;
            @(negedge sclk);
            wdt_fault = 1'b0;
            write_ctl(8'hA5, 3'b011);
            @(negedge sclk);
            wdt_fault = 1'b1;
            wdt_proc_only = 1'b0;
            @(negedge sclk);
            wdt_fault = 1'b0;
            while ((busy || idx < 2) && idx < 80) begin
                if (!ext_rst_n) begin
                    ext_low++;
                    if (ext_idx < 0) ext_idx = idx;
                end
                if (rst_type == 2'd3 && t3_idx < 0) t3_idx = idx;
                idx++;
                @(negedge sclk);
            end
            repeat (4) @(negedge mclk);
            if (rst_type == 2'd3 && t3_idx < 0) t3_idx = idx;
            chk(ext_idx >= 0 && t3_idx > ext_idx, "R10 watchdog before software", t3_idx, ext_idx + 1);
            chk(ext_low == 8, "R10 watchdog pulse", ext_low, 8);
            chk(rst_type == 2'd3 && !busy, "R10 software served last", {busy, rst_type}, 3);
        end

        finished = 1;
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge mclk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            finish_up();
        end
    end

endmodule